// File: doc/BRIEF.md
# Gray-Coded Sample Counter Crossing

This block counts sample strobes in a fast acquisition clock domain and makes the running total readable in a slower processing clock domain. The two clocks have no fixed phase relationship. The count saturates at a ceiling and then stays there.

The binary count never crosses the boundary directly. The source domain turns each new count into a Gray word and holds it in a flip-flop, so consecutive words differ in a single bit and no combinational glitch reaches the far side. The destination domain passes every bit of that word through its own two-flop synchroniser. It then decodes the word back to binary with an XOR prefix chain and registers the result.

A capture made while the source is updating therefore returns either the old count or the new one. It never returns a mix of the two. The processing logic reads `dst_count` at any time and gets a value that may trail the true total by a few of its own cycles, but it is always a value the counter actually held.

Top module: `gray_count_cdc`

## Requirements
- R1: While either reset is asserted (active low), the state of that domain is cleared. After both resets are released, `dst_count` reads 0.
- R2: On every source clock edge where `sample_vld` is 1 and the count is below SAT_MAX (32768 by default), the source count rises by exactly one.
- R3: On a source clock edge where `sample_vld` is 0, the count and its Gray word keep their values, so `dst_count` does not change once it has settled.
- R4: The count never goes above SAT_MAX. Strobes that arrive at the ceiling are ignored and `dst_count` stays at SAT_MAX.
- R5: The registered Gray word changes in at most one bit position from one source cycle to the next, where Gray(b) = b XOR (b >> 1).
- R6: Between resets, `dst_count` never decreases and never exceeds SAT_MAX.
- R7: Once strobes stop, `dst_count` equals the source count within 4 destination clock cycles. The path is one source register, two synchroniser stages and one output register.
- R8: Asserting only the destination reset clears `dst_count` to 0 and leaves the source count intact. After release, `dst_count` returns to the held count within 4 destination cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Acquisition clock |
| rst_src_n | input | 1 | Asynchronous reset of the source domain, active low |
| sample_vld | input | 1 | Sample strobe, one count per high cycle |
| clk_dst | input | 1 | Processing clock, unrelated phase |
| rst_dst_n | input | 1 | Asynchronous reset of the destination domain, active low |
| dst_count | output | CNT_W | Count as seen in the processing domain |

## Verification
A strobe sampled at a source edge updates the Gray register on that same edge. That value then needs two destination edges to clear the synchroniser and one more to reach `dst_count`, so a new total is due three destination edges after the source edge that produced it. The bench stops strobing and waits six destination cycles before it compares `dst_count` against its own saturating tally. While strobes are still running, it checks at every falling destination edge that the value never decreases, never passes the ceiling and never runs ahead of the tally.

// File: rtl/gcc_pkg.sv
package gcc_pkg;

  localparam int unsigned MAX_W = 32;

  typedef logic [MAX_W-1:0] word_t;

  // binary to reflected Gray
  function automatic word_t bin2gray(input word_t b);
    return b ^ (b >> 1);
  endfunction

  // Gray to binary: prefix XOR from the top bit down
  function automatic word_t gray2bin(input word_t g);
    word_t b;
    b[MAX_W-1] = g[MAX_W-1];
    for (int i = MAX_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/gcc_src_counter.sv
module gcc_src_counter
  import gcc_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned SAT_MAX = 32768
) (
  input  logic             clk_src,
  input  logic             rst_src_n,
  input  logic             sample_vld,
  output logic [CNT_W-1:0] gray_q
);

  localparam logic [CNT_W-1:0] SatVal = CNT_W'(SAT_MAX);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_sat;
  logic             cnt_inc;

  assign cnt_sat = (cnt_q == SatVal);
  assign cnt_inc = sample_vld && !cnt_sat;
  assign cnt_nxt = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_src or negedge rst_src_n) begin
    if (!rst_src_n) begin
      cnt_q  <= '0;
      gray_q <= '0;
    end else if (cnt_inc) begin
      cnt_q  <= cnt_nxt;
      gray_q <= CNT_W'(bin2gray(word_t'(cnt_nxt)));
    end
  end

  AST_SRC_STEP: assert property (@(posedge clk_src) disable iff (!rst_src_n)
    cnt_inc |=> (cnt_q == $past(cnt_q) + CNT_W'(1))) else $error("step"); // R2

  AST_SRC_HOLD_IDLE: assert property (@(posedge clk_src) disable iff (!rst_src_n)
    !sample_vld |=> ($stable(cnt_q) && $stable(gray_q))) else $error("idle"); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk_src) disable iff (!rst_src_n)
    cnt_q <= SatVal) else $error("overflow"); // R4

  AST_GRAY_ONE_BIT: assert property (@(posedge clk_src) disable iff (!rst_src_n)
    $countones(gray_q ^ $past(gray_q)) <= 1) else $error("gray"); // R5

endmodule

// File: rtl/gcc_sync_bank.sv
module gcc_sync_bank #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_dst,
  input  logic         rst_dst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_dst or negedge rst_dst_n) begin
      if (!rst_dst_n) chain_q <= '0;
      else            chain_q <= {chain_q[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/gcc_dst_decode.sv
module gcc_dst_decode
  import gcc_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned SAT_MAX = 32768
) (
  input  logic             clk_dst,
  input  logic             rst_dst_n,
  input  logic [CNT_W-1:0] gray_sync,
  output logic [CNT_W-1:0] count_q
);

  logic [CNT_W-1:0] count_dec;
  assign count_dec = CNT_W'(gray2bin(word_t'(gray_sync)));

  always_ff @(posedge clk_dst or negedge rst_dst_n) begin
    if (!rst_dst_n) count_q <= '0;
    else            count_q <= count_dec;
  end

  AST_DST_MONOTONIC: assert property (@(posedge clk_dst) disable iff (!rst_dst_n)
    count_q >= $past(count_q)) else $error("decrease"); // R6

  AST_DST_CEILING: assert property (@(posedge clk_dst) disable iff (!rst_dst_n)
    count_q <= CNT_W'(SAT_MAX)) else $error("ceiling"); // R6

endmodule

// File: rtl/gray_count_cdc.sv
module gray_count_cdc #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SAT_MAX     = 32768,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_src,
  input  logic             rst_src_n,
  input  logic             sample_vld,
  input  logic             clk_dst,
  input  logic             rst_dst_n,
  output logic [CNT_W-1:0] dst_count
);

  logic [CNT_W-1:0] gray_src;
  logic [CNT_W-1:0] gray_sync;

  gcc_src_counter #(.CNT_W(CNT_W), .SAT_MAX(SAT_MAX)) u_src (
    .clk_src    (clk_src),
    .rst_src_n  (rst_src_n),
    .sample_vld (sample_vld),
    .gray_q     (gray_src)
  );

  gcc_sync_bank #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_dst   (clk_dst),
    .rst_dst_n (rst_dst_n),
    .d_async   (gray_src),
    .q_sync    (gray_sync)
  );

  gcc_dst_decode #(.CNT_W(CNT_W), .SAT_MAX(SAT_MAX)) u_dec (
    .clk_dst   (clk_dst),
    .rst_dst_n (rst_dst_n),
    .gray_sync (gray_sync),
    .count_q   (dst_count)
  );

endmodule

// File: tb/gray_count_cdc_tb_top.sv
`timescale 1ns/10ps
module gray_count_cdc_tb_top;

  localparam int unsigned CNT_W   = 16;
  localparam int unsigned SAT_MAX = 32768;

  logic clk_src = 1'b0, clk_dst = 1'b0;
  logic rst_src_n = 1'b0, rst_dst_n = 1'b0;
  logic sample_vld = 1'b0;
  logic [CNT_W-1:0] dst_count;

  int n_tests = 0, n_fail = 0;
  int unsigned tally = 0;
  int unsigned prev_seen = 0;
  bit mon_en = 1'b0;
  bit finished = 1'b0;

  always #5 clk_src = ~clk_src;
  initial begin
    #3.7;
    forever #10.13 clk_dst = ~clk_dst;
  end

  gray_count_cdc #(.CNT_W(CNT_W), .SAT_MAX(SAT_MAX), .SYNC_STAGES(2)) dut_i (
    .clk_src(clk_src), .rst_src_n(rst_src_n), .sample_vld(sample_vld),
    .clk_dst(clk_dst), .rst_dst_n(rst_dst_n), .dst_count(dst_count)
  );

  task automatic check(input string req, input bit ok, input int unsigned act, input int unsigned expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // continuous legality monitor (R6, R2 upper bound)
  always @(negedge clk_dst) begin
    if (mon_en) begin
      check("R6 no decrease", int'(dst_count) >= prev_seen, dst_count, prev_seen);
      check("R6 ceiling", dst_count <= SAT_MAX, dst_count, SAT_MAX);
      check("R2 not ahead", dst_count <= tally, dst_count, tally);
      prev_seen = dst_count;
    end
  end

  // mode 0: always, 1: alternate, 2: pseudo-random
  task automatic strobe(input int n, input int mode);
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_src);
      case (mode)
        0: sample_vld = 1'b1;
        1: sample_vld = i[0];
        default: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          sample_vld = lfsr[0];
        end
      endcase
      if (sample_vld && tally < SAT_MAX) tally = tally + 1;
    end
    @(negedge clk_src);
    sample_vld = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk_dst);
  endtask

  initial begin
    repeat (4) @(negedge clk_src);
    rst_src_n = 1'b1;
    rst_dst_n = 1'b1;
    repeat (3) @(negedge clk_dst);
    check("R1 reset value", dst_count == 0, dst_count, 0);
    mon_en = 1'b1;

    strobe(100, 0); settle();
    check("R2 steady burst", dst_count == tally, dst_count, tally);
    check("R7 latency steady", dst_count == 100, dst_count, 100);

    repeat (50) @(negedge clk_src);
    check("R3 idle holds", dst_count == tally, dst_count, tally);

    strobe(200, 1); settle();
    check("R2 alternate", dst_count == tally, dst_count, tally);

    for (int k = 0; k < 5; k++) begin
      strobe(37 + 13 * k, 2); settle();
      check("R7 random burst", dst_count == tally, dst_count, tally);
    end

    strobe(SAT_MAX, 0); settle();
    check("R4 saturated", dst_count == SAT_MAX, dst_count, SAT_MAX);
    strobe(300, 0); settle();
    check("R4 stays at ceiling", dst_count == SAT_MAX, dst_count, SAT_MAX);

    mon_en = 1'b0;
    @(negedge clk_dst);
    rst_dst_n = 1'b0;
    @(negedge clk_dst);
    check("R8 dst reset clears", dst_count == 0, dst_count, 0);
    check("R1 during reset", dst_count == 0, dst_count, 0);
    rst_dst_n = 1'b1;
    prev_seen = 0;
    mon_en = 1'b1;
    repeat (4) @(negedge clk_dst);
    check("R8 recovers held count", dst_count == SAT_MAX, dst_count, SAT_MAX);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", dst_count, tally);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule